// File: doc/BRIEF.md
# RTC Interrupt and Watchdog Controller

This block produces the interrupt and processor-reset signals for a real-time clock. It has three interrupt sources, and each one is enabled on its own. The first is an alarm, which compares the current BCD seconds, minutes and hours against programmed values. The second is a periodic source: a 4-bit code selects one of 15 tick lines, which run from prescaler taps up to the day tick. The third is a power-fail flag, raised by a digital sense input. Each source that fires sets a status flag. The flag stays set until the host reads the status. While any flag is set, the block pulls the active-low interrupt line. At all other times it leaves the line undriven.

The same block contains a watchdog. When the watchdog is enabled, the host must toggle the chip-enable line within a fixed number of watchdog ticks. If it misses that window, the block drives a CPU reset pulse of fixed width. The same reset pulse can also be triggered by the onset of power-fail, under a separate enable. The time values, alarm values and all timebase ticks arrive as inputs. The serial bus and the analog sensing sit outside this block.

Top module: `rtc_irq_wdog`

## Requirements
- R1: After reset: status_o is 0, irq_oe_o is 0, irq_n_o is 1 and cpur_n_o is 1.
- R2: When alm_en_i is 1 and the seconds, minutes and hours inputs all become equal to the alarm inputs, status_o bit 0 is set at the next clock edge.
- R3: The alarm fires only in the cycle in which the full three-field match becomes true. A match that continues to hold does not set the flag again after a clear. A match on only some of the fields never sets the flag.
- R4: While alm_en_i is 0, a match does not set status_o bit 0.
- R5: per_sel_i selects the periodic tick line. Code k in 1..11 selects presc_tick_i[k-1]. Codes 12, 13, 14 and 15 select sec_tick_i, min_tick_i, hour_tick_i and day_tick_i. A pulse on the selected line sets status_o bit 1. A pulse on any other line does not.
- R6: per_sel_i = 0 disables the periodic source.
- R7: When pf_en_i is 1, a rising edge of pf_sense_i sets status_o bit 2. A sense input that stays high does not set the flag again after a clear.
- R8: irq_oe_o is 1 exactly when status_o is nonzero, and irq_n_o is then 0. Otherwise irq_n_o is 1.
- R9: A one-cycle stat_rd_i pulse clears every flag at the next edge. If a source fires in the same cycle as the read, its flag stays set.
- R10: Without a read, a set flag stays set.
- R11: While wdog_en_i is 1, cpur_n_o goes low on the WD_TIMEOUT-th tick of presc_tick_i[WD_TAP] that occurs without a ce_i toggle. Any ce_i edge restarts the count. While wdog_en_i is 0, the watchdog never asserts the reset.
- R12: The reset pulse on cpur_n_o lasts RST_W watchdog ticks. After the pulse is released, the timeout count starts again from zero.
- R13: When cpur_pf_en_i is 1, a rising edge of pf_sense_i starts the same reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_tick_i | input | 11 | Prescaler tap tick pulses, one cycle each |
| sec_tick_i | input | 1 | Seconds tick |
| min_tick_i | input | 1 | Minutes tick |
| hour_tick_i | input | 1 | Hours tick |
| day_tick_i | input | 1 | Day tick |
| cur_sec_i | input | 8 | Current seconds, BCD |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hour_i | input | 8 | Current hours, BCD |
| alm_sec_i | input | 8 | Alarm seconds, BCD |
| alm_min_i | input | 8 | Alarm minutes, BCD |
| alm_hour_i | input | 8 | Alarm hours, BCD |
| alm_en_i | input | 1 | Alarm source enable |
| per_sel_i | input | 4 | Periodic rate code; 0 disables |
| pf_en_i | input | 1 | Power-fail interrupt enable |
| pf_sense_i | input | 1 | Power-fail sense, high means fail |
| stat_rd_i | input | 1 | Status read strobe; clears the flags |
| status_o | output | 3 | Flags: bit 0 alarm, bit 1 periodic, bit 2 power-fail |
| irq_oe_o | output | 1 | Interrupt pull-low enable |
| irq_n_o | output | 1 | Interrupt level, active low |
| wdog_en_i | input | 1 | Watchdog enable |
| ce_i | input | 1 | Chip-enable line; any edge services the watchdog |
| cpur_pf_en_i | input | 1 | Enables the CPU reset on power-fail onset |
| cpur_n_o | output | 1 | CPU reset, active low |

## Verification
A wrong internal state shows at the ports in two ways. A stale alarm-match history makes the alarm fire again one cycle after a clear, or makes it miss the edge completely. A mis-decoded rate code sets status_o bit 1 on the wrong tick line in the same edge. A watchdog counter that is off by one moves the fall of cpur_n_o one tick early or late. If the counter does not restart after a pulse, the second timeout appears at the wrong tick. The flag and interrupt pins follow the flag register combinationally, so a lost or stuck flag is visible one clock after the event or the read that caused it.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int PRE_TAPS = 11;          // 11 taps + sec/min/hour/day = 15 rates
  localparam int NSRC     = 3;
  localparam int SEL_W    = 4;
  localparam int BCD_W    = 8;
  localparam int SRC_ALM  = 0;
  localparam int SRC_PER  = 1;
  localparam int SRC_PF   = 2;
  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [NSRC-1:0]  src_vec_t;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  bcd_t cur_sec_i,
  input  bcd_t cur_min_i,
  input  bcd_t cur_hour_i,
  input  bcd_t alm_sec_i,
  input  bcd_t alm_min_i,
  input  bcd_t alm_hour_i,
  output logic hit_o
);
  logic match_c, match_q;

  assign match_c = (cur_sec_i == alm_sec_i) && (cur_min_i == alm_min_i) &&
                   (cur_hour_i == alm_hour_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= match_c;
  end

  // one hit per match onset, history tracked even when disabled
  assign hit_o = en_i && match_c && !match_q;
endmodule

// File: rtl/rtc_per_sel.sv
module rtc_per_sel
  import rtc_irq_pkg::*;
(
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [PRE_TAPS-1:0] presc_tick_i,
  input  logic                sec_tick_i,
  input  logic                min_tick_i,
  input  logic                hour_tick_i,
  input  logic                day_tick_i,
  output logic                hit_o
);
  localparam int NLINE = 1 << SEL_W;
  logic [NLINE-1:0] line;

  assign line[0] = 1'b0;
  for (genvar k = 1; k < NLINE; k++) begin : g_line
    if (k <= PRE_TAPS) begin : g_pre
      assign line[k] = presc_tick_i[k-1];
    end else if (k == PRE_TAPS + 1) begin : g_sec
      assign line[k] = sec_tick_i;
    end else if (k == PRE_TAPS + 2) begin : g_min
      assign line[k] = min_tick_i;
    end else if (k == PRE_TAPS + 3) begin : g_hour
      assign line[k] = hour_tick_i;
    end else begin : g_day
      assign line[k] = day_tick_i;
    end
  end

  assign hit_o = line[sel_i];
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t set_i,
  input  logic     rd_i,
  output src_vec_t flags_o
);
  src_vec_t flags_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[i] <= 1'b0;
      else         flags_q[i] <= set_i[i] | (flags_q[i] & ~rd_i);  // set wins
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog #(
  parameter int TIMEOUT = 4,
  parameter int RST_W   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ce_i,
  input  logic tick_i,
  input  logic pf_trip_i,
  output logic cpur_n_o
);
  localparam int MAXC = (TIMEOUT > RST_W) ? TIMEOUT : RST_W;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_W - 1);

  logic          ce_q, in_rst_q;
  logic [CW-1:0] cnt_q;
  logic          toggle;

  assign toggle = ce_i ^ ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q     <= 1'b0;
      in_rst_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      ce_q <= ce_i;
      if (in_rst_q) begin
        if (tick_i) begin
          if (cnt_q == RST_LAST) begin
            in_rst_q <= 1'b0;
            cnt_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else if (pf_trip_i) begin
        in_rst_q <= 1'b1;
        cnt_q    <= '0;
      end else if (!en_i || toggle) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == TO_LAST) begin
          in_rst_q <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cpur_n_o = ~in_rst_q;
endmodule

// File: rtl/rtc_irq_wdog.sv
module rtc_irq_wdog
  import rtc_irq_pkg::*;
#(
  parameter int WD_TAP     = 0,
  parameter int WD_TIMEOUT = 4,
  parameter int RST_W      = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PRE_TAPS-1:0] presc_tick_i,
  input  logic                sec_tick_i,
  input  logic                min_tick_i,
  input  logic                hour_tick_i,
  input  logic                day_tick_i,
  input  logic [BCD_W-1:0]    cur_sec_i,
  input  logic [BCD_W-1:0]    cur_min_i,
  input  logic [BCD_W-1:0]    cur_hour_i,
  input  logic [BCD_W-1:0]    alm_sec_i,
  input  logic [BCD_W-1:0]    alm_min_i,
  input  logic [BCD_W-1:0]    alm_hour_i,
  input  logic                alm_en_i,
  input  logic [SEL_W-1:0]    per_sel_i,
  input  logic                pf_en_i,
  input  logic                pf_sense_i,
  input  logic                stat_rd_i,
  output logic [NSRC-1:0]     status_o,
  output logic                irq_oe_o,
  output logic                irq_n_o,
  input  logic                wdog_en_i,
  input  logic                ce_i,
  input  logic                cpur_pf_en_i,
  output logic                cpur_n_o
);
  src_vec_t set;
  logic     alm_hit, per_hit, pf_q, pf_rise;

  rtc_alarm_match i_alarm (
    .clk_i, .rst_ni, .en_i(alm_en_i),
    .cur_sec_i, .cur_min_i, .cur_hour_i,
    .alm_sec_i, .alm_min_i, .alm_hour_i,
    .hit_o(alm_hit)
  );

  rtc_per_sel i_per (
    .sel_i(per_sel_i), .presc_tick_i, .sec_tick_i, .min_tick_i,
    .hour_tick_i, .day_tick_i, .hit_o(per_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pf_q <= 1'b0;
    else         pf_q <= pf_sense_i;
  end
  assign pf_rise = pf_sense_i & ~pf_q;

  always_comb begin
    set          = '0;
    set[SRC_ALM] = alm_hit;
    set[SRC_PER] = per_hit;
    set[SRC_PF]  = pf_en_i & pf_rise;
  end

  rtc_irq_status i_stat (
    .clk_i, .rst_ni, .set_i(set), .rd_i(stat_rd_i), .flags_o(status_o)
  );

  assign irq_oe_o = |status_o;
  assign irq_n_o  = ~irq_oe_o;

  rtc_wdog #(.TIMEOUT(WD_TIMEOUT), .RST_W(RST_W)) i_wdog (
    .clk_i, .rst_ni, .en_i(wdog_en_i), .ce_i,
    .tick_i(presc_tick_i[WD_TAP]),
    .pf_trip_i(cpur_pf_en_i & pf_rise),
    .cpur_n_o
  );
endmodule

// File: rtl/rtc_irq_wdog_chk.sv
module rtc_irq_wdog_chk
  import rtc_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wd_tick_i,
  input logic             sec_tick_i,
  input logic [SEL_W-1:0] per_sel_i,
  input logic             pf_en_i,
  input logic             pf_sense_i,
  input logic             stat_rd_i,
  input logic [NSRC-1:0]  status_o,
  input logic             irq_oe_o,
  input logic             irq_n_o,
  input logic             wdog_en_i,
  input logic             cpur_pf_en_i,
  input logic             cpur_n_o
);
  assert_sec_rate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_sel_i == 4'd12 && sec_tick_i) |=> status_o[1]);

  assert_irq_follows_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != '0) |-> (irq_oe_o && !irq_n_o));

  assert_irq_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == '0) |-> (!irq_oe_o && irq_n_o));

  assert_pf_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_en_i && pf_sense_i && !$past(pf_sense_i)) |=> status_o[2]);

  assert_flags_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  assert_rst_releases_on_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpur_n_o && !wd_tick_i) |=> !cpur_n_o);

  assert_wdog_off_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpur_n_o && !wdog_en_i && !(cpur_pf_en_i && pf_sense_i)) |=> cpur_n_o);
endmodule

bind rtc_irq_wdog rtc_irq_wdog_chk i_chk (
  .clk_i, .rst_ni, .wd_tick_i(presc_tick_i[WD_TAP]), .sec_tick_i, .per_sel_i,
  .pf_en_i, .pf_sense_i, .stat_rd_i, .status_o, .irq_oe_o, .irq_n_o,
  .wdog_en_i, .cpur_pf_en_i, .cpur_n_o
);

// File: tb/test_rtc_irq_wdog.sv
module test_rtc_irq_wdog;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [14:0] tl = '0;               // 0..10 prescaler, 11 sec, 12 min, 13 hour, 14 day
  logic [7:0]  cs = 8'h00, cm = 8'h00, ch = 8'h00;
  logic [7:0]  as = 8'h99, am = 8'h99, ah = 8'h99;
  logic        alm_en = 0, pf_en = 0, pf_s = 0, rd = 0, wd_en = 0, ce = 0, cpf_en = 0;
  logic [3:0]  sel = '0;
  logic [2:0]  status;
  logic        irq_oe, irq_n, cpur_n;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  rtc_irq_wdog i_rtc_irq_wdog (
    .clk_i(clk), .rst_ni(rst_n), .presc_tick_i(tl[10:0]),
    .sec_tick_i(tl[11]), .min_tick_i(tl[12]), .hour_tick_i(tl[13]), .day_tick_i(tl[14]),
    .cur_sec_i(cs), .cur_min_i(cm), .cur_hour_i(ch),
    .alm_sec_i(as), .alm_min_i(am), .alm_hour_i(ah), .alm_en_i(alm_en),
    .per_sel_i(sel), .pf_en_i(pf_en), .pf_sense_i(pf_s), .stat_rd_i(rd),
    .status_o(status), .irq_oe_o(irq_oe), .irq_n_o(irq_n),
    .wdog_en_i(wd_en), .ce_i(ce), .cpur_pf_en_i(cpf_en), .cpur_n_o(cpur_n)
  );

  // {sel, line, expected periodic flag}
  localparam logic [8:0] PER_TAB [11] = '{
    {4'd1,  4'd0,  1'b1}, {4'd1,  4'd1,  1'b0}, {4'd5,  4'd4,  1'b1},
    {4'd11, 4'd10, 1'b1}, {4'd12, 4'd11, 1'b1}, {4'd13, 4'd12, 1'b1},
    {4'd14, 4'd13, 1'b1}, {4'd15, 4'd14, 1'b1}, {4'd15, 4'd13, 1'b0},
    {4'd0,  4'd0,  1'b0}, {4'd12, 4'd12, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    tl[idx] = 1'b1;
    step();
    tl = '0;
  endtask

  task automatic clear();
    rd = 1'b1;
    step();
    rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    chk(status == 0 && !irq_oe && irq_n && cpur_n, "R1", {status, irq_oe, irq_n, cpur_n}, 3);

    foreach (PER_TAB[i]) begin
      sel = PER_TAB[i][8:5];
      clear();
      pulse(int'(PER_TAB[i][4:1]));
      chk(status == {1'b0, PER_TAB[i][0], 1'b0}, (PER_TAB[i][8:5] == 0) ? "R6" : "R5",
          status, {PER_TAB[i][0], 1'b0});
    end

    // R9: set in the same cycle as a read wins
    sel = 4'd12;
    clear();
    rd = 1'b1; tl[11] = 1'b1;
    step();
    rd = 1'b0; tl = '0;
    chk(status == 3'b010, "R9 set wins", status, 2);
    step(5);
    chk(status == 3'b010, "R10 hold", status, 2);
    clear();
    chk(status == 0 && !irq_oe && irq_n, "R9 clear", {status, irq_oe}, 0);
    sel = 4'd0;

    // alarm
    alm_en = 1; ah = 8'h12; am = 8'h30; as = 8'h45;
    ch = 8'h12; cm = 8'h30; cs = 8'h44;
    step(2);
    clear();
    cs = 8'h45;
    step();
    chk(status == 3'b001, "R2", status, 1);
    chk(irq_oe && !irq_n, "R8", {irq_oe, irq_n}, 2);
    clear();
    step(4);
    chk(status == 0, "R3 no refire", status, 0);
    ch = 8'h13; cs = 8'h44;
    step();
    cs = 8'h45;
    step(2);
    chk(status == 0, "R3 partial", status, 0);
    alm_en = 0; ch = 8'h12; cs = 8'h44;
    step();
    cs = 8'h45;
    step(2);
    chk(status == 0 && !irq_oe, "R4", {status, irq_oe}, 0);
    as = 8'h99;

    // power-fail flag
    pf_en = 1; pf_s = 1;
    step();
    chk(status == 3'b100, "R7", status, 4);
    chk(cpur_n, "R13 gated off", cpur_n, 1);
    clear();
    step(2);
    chk(status == 0, "R7 level no refire", status, 0);
    pf_s = 0; pf_en = 0;
    step();

    // power-fail reset
    cpf_en = 1; pf_s = 1;
    step();
    chk(!cpur_n && status == 0, "R13", {status, cpur_n}, 0);
    pulse(0);
    chk(!cpur_n, "R12 width", cpur_n, 0);
    pulse(0);
    chk(cpur_n, "R12 release", cpur_n, 1);
    pf_s = 0; cpf_en = 0;
    step();

    // watchdog
    wd_en = 1; ce = ~ce;
    step();
    for (int i = 0; i < 3; i++) pulse(0);
    chk(cpur_n, "R11 before timeout", cpur_n, 1);
    pulse(0);
    chk(!cpur_n, "R11 timeout", cpur_n, 0);
    pulse(0);
    chk(!cpur_n, "R12 width", cpur_n, 0);
    pulse(0);
    chk(cpur_n, "R12 release", cpur_n, 1);
    for (int i = 0; i < 3; i++) pulse(0);
    chk(cpur_n, "R12 restart", cpur_n, 1);
    pulse(0);
    chk(!cpur_n, "R12 second timeout", cpur_n, 0);
    pulse(0); pulse(0);
    for (int i = 0; i < 3; i++) pulse(0);
    ce = ~ce;
    step();
    for (int i = 0; i < 3; i++) pulse(0);
    chk(cpur_n, "R11 toggle restarts", cpur_n, 1);
    wd_en = 0;
    for (int i = 0; i < 10; i++) pulse(0);
    chk(cpur_n, "R11 disabled", cpur_n, 1);

    finish_run();
  end
endmodule